// File: doc/BRIEF.md
# Carry-Aware Integer ALU

This block evaluates one of ten data-processing operations on a 32-bit first operand and a 32-bit second operand that arrives already prepared, with no shifting inside. The result is combinational. A single carry flag sits in a one-bit status register. The arithmetic forms either consume this flag or refresh it: plain, carry-chained and reverse-order addition and subtraction. The bitwise forms never touch it.

A sequencer presents an opcode and the operands, then raises the update enable on the cycle whose carry outcome should be kept. The flag is written on the next rising clock edge. For additions the flag means a carry out of bit 31. For subtractions it means a borrow out of bit 31. The carry-chained subtract forms take that borrow away from their result, so multi-word arithmetic chains word by word.

Top module: `alu_core`

## Requirements
- R1: Opcode 0 returns rn + op2 modulo 2^32. When updating, the flag becomes 1 exactly when the true sum needs a 33rd bit. For example, 0xFFFFFFFF + 1 gives 0 with flag 1.
- R2: Opcode 1 returns rn - op2 and opcode 2 returns op2 - rn. When updating, the flag becomes 1 exactly when the subtrahend exceeds the minuend (a borrow out of bit 31).
- R3: Opcode 3 returns rn + op2 + C, where C is the stored flag. When updating, the flag becomes the carry out of that three-term sum.
- R4: Opcode 4 returns rn - op2 - C and opcode 5 returns op2 - rn - C. When updating, the flag becomes 1 exactly when the subtracted total exceeds the minuend.
- R5: Opcode 6 returns rn & op2, opcode 8 returns rn | op2 and opcode 9 returns rn ^ op2.
- R6: Opcode 7 returns rn & ~op2, which clears each bit of rn that is set in op2.
- R7: Opcodes 6 to 9 leave the flag unchanged even while the update enable is high.
- R8: While the update enable is low, the flag keeps its value on every opcode.
- R9: Opcodes 10 to 15 return 0 and leave the flag unchanged.
- R10: A synchronous active-low reset clears the flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 4 | Operation select (0 to 9 defined) |
| rn | input | 32 | First operand |
| op2 | input | 32 | Prepared second operand |
| upd_en | input | 1 | Allow this operation to write the flag |
| result | output | 32 | Combinational operation result |
| carry_q | output | 1 | Stored carry/borrow flag |

## Verification
The embedded assertions check the flag-retention rules on every cycle: the flag holds when updating is disabled, when a bitwise opcode runs and when an undefined opcode runs. They also check that undefined opcodes yield zero, that the flag is clear after reset, and that a full-scale addition sets the flag. The result values of each arithmetic and bitwise form, and the way the stored flag enters the carry-chained forms, can only be shown by the bench's scenarios. Those scenarios set up a known flag and then compare against hand-computed values, including the wrap and borrow corners.

// File: rtl/alu_pkg.sv
// Package alu_pkg
// Shared operation codes and classification helpers for the ALU.
// Assumes a 4-bit opcode. Values above the last defined code are unused.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_RSB = 4'd2,
        OP_ADC = 4'd3,
        OP_SBC = 4'd4,
        OP_RSC = 4'd5,
        OP_AND = 4'd6,
        OP_BIC = 4'd7,
        OP_ORR = 4'd8,
        OP_EOR = 4'd9
    } alu_op_e;

    // True for the six forms that produce a carry or borrow
    function automatic logic op_is_arith(input logic [3:0] code);
        return (code <= 4'd5);
    endfunction

    // True for the four bitwise forms
    function automatic logic op_is_logic(input logic [3:0] code);
        return (code >= 4'd6) && (code <= 4'd9);
    endfunction

endpackage

// File: rtl/alu_arith.sv
// Module alu_arith
// Adder/subtractor for the six arithmetic forms. The reverse forms swap the
// operands, and the chained forms fold in the stored flag. For additions the
// flag output is the carry out of the top bit. For subtractions it is the
// borrow out of the top bit.
// Assumes op is one of the arithmetic codes. Other codes give don't-care data.
module alu_arith
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int EXT = WIDTH + 1;

    logic             swap_ops;
    logic             use_cin;
    logic             is_add;
    logic [WIDTH-1:0] lhs;
    logic [WIDTH-1:0] rhs;
    logic [EXT-1:0]   cterm;
    logic [EXT-1:0]   sum_ext;
    logic [EXT-1:0]   diff_ext;

    // Decode the operand order, carry use and direction from the opcode
    always_comb begin
        swap_ops = (op == OP_RSB) || (op == OP_RSC);
        use_cin  = (op == OP_ADC) || (op == OP_SBC) || (op == OP_RSC);
        is_add   = (op == OP_ADD) || (op == OP_ADC);
    end

    // Order the operands and form the carry term
    always_comb begin
        lhs   = swap_ops ? b : a;
        rhs   = swap_ops ? a : b;
        cterm = {{WIDTH{1'b0}}, (use_cin & cin)};
    end

    // Widened add and subtract. The extra top bit is carry or borrow.
    always_comb begin
        sum_ext  = {1'b0, lhs} + {1'b0, rhs} + cterm;
        diff_ext = {1'b0, lhs} - {1'b0, rhs} - cterm;
    end

    // Select the direction
    always_comb begin
        res  = is_add ? sum_ext[WIDTH-1:0] : diff_ext[WIDTH-1:0];
        cout = is_add ? sum_ext[EXT-1]     : diff_ext[EXT-1];
    end

endmodule

// File: rtl/alu_logic.sv
// Module alu_logic
// Bitwise unit for and, bit-clear, or and exclusive-or, built per bit.
// Assumes op is a bitwise code. Other codes return zero.
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Per-bit function select
        always_comb begin
            unique case (op)
                OP_AND:  res[i] = a[i] & b[i];
                OP_BIC:  res[i] = a[i] & ~b[i];
                OP_ORR:  res[i] = a[i] | b[i];
                OP_EOR:  res[i] = a[i] ^ b[i];
                default: res[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alu_flag_reg.sv
// Module alu_flag_reg
// One-bit status register holding the carry/borrow flag.
// Assumes a synchronous active-low reset. It loads only when wr_en is high.
module alu_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic d,
    output logic q
);
    // Flag storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (wr_en)
            q <= d;
    end

    // Flag is clear on the first edge after reset releases
    assert_reset_clear_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> (q == 1'b0));

endmodule

// File: rtl/alu_core.sv
// Module alu_core
// Top level of the ALU. It routes the operands to the arithmetic and bitwise
// units, selects the result, and gates the flag write so that only the
// arithmetic forms update the flag while upd_en is high.
// Assumes the operands are already prepared. The result is combinational.
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] rn,
    input  logic [WIDTH-1:0] op2,
    input  logic             upd_en,
    output logic [WIDTH-1:0] result,
    output logic             carry_q
);
    logic [WIDTH-1:0] arith_res;
    logic             arith_cout;
    logic [WIDTH-1:0] logic_res;
    logic             flag_wr;
    logic             sel_arith;
    logic             sel_logic;

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op   (op),
        .a    (rn),
        .b    (op2),
        .cin  (carry_q),
        .res  (arith_res),
        .cout (arith_cout)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op  (op),
        .a   (rn),
        .b   (op2),
        .res (logic_res)
    );

    // Classify the opcode
    always_comb begin
        sel_arith = op_is_arith(op);
        sel_logic = op_is_logic(op);
    end

    // Result select. Undefined codes give zero.
    always_comb begin
        if (sel_arith)
            result = arith_res;
        else if (sel_logic)
            result = logic_res;
        else
            result = '0;
    end

    // Only arithmetic forms may write the flag
    always_comb flag_wr = upd_en & sel_arith;

    alu_flag_reg u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (flag_wr),
        .d     (arith_cout),
        .q     (carry_q)
    );

    // Undefined opcodes yield zero at the port
    always_comb begin
        if (rst_n && (op > 4'd9))
            assert_undef_zero_R9: assert (result == '0);
    end

    assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(carry_q));

    assert_logic_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op >= 4'd6 && op <= 4'd9) |=> $stable(carry_q));

    assert_undef_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd9) |=> $stable(carry_q));

    assert_full_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op == 4'd0 && rn == {WIDTH{1'b1}} && op2 != '0) |=> carry_q);

endmodule

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] rn = '0;
    logic [31:0] op2 = '0;
    logic        upd_en = 1'b0;
    logic [31:0] result;
    logic        carry_q;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    alu_core dut (
        .clk(clk), .rst_n(rst_n), .op(op), .rn(rn), .op2(op2),
        .upd_en(upd_en), .result(result), .carry_q(carry_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation, check the result, then the flag after the edge
    task automatic run(input string req, input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic u,
                       input logic [31:0] exp_res, input logic exp_c);
        @(negedge clk);
        op = o; rn = a; op2 = b; upd_en = u;
        #1 check(req, result, exp_res);
        @(negedge clk);
        check(req, {31'd0, carry_q}, {31'd0, exp_c});
        upd_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", {31'd0, carry_q}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run("R1", 4'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 32'd0, 1'b1);
        run("R1", 4'd0, 32'd5, 32'd7, 1'b1, 32'd12, 1'b0);
        run("R1", 4'd0, 32'h80000000, 32'h80000000, 1'b1, 32'd0, 1'b1);
    endtask

    task automatic t_sub();
        run("R2", 4'd1, 32'd10, 32'd3, 1'b1, 32'd7, 1'b0);
        run("R2", 4'd1, 32'd0, 32'd1, 1'b1, 32'hFFFFFFFF, 1'b1);
        run("R2", 4'd2, 32'd3, 32'd10, 1'b1, 32'd7, 1'b0);
        run("R2", 4'd2, 32'd10, 32'd3, 1'b1, 32'hFFFFFFF9, 1'b1);
    endtask

    task automatic t_adc();
        run("R3", 4'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 32'd0, 1'b1);
        run("R3", 4'd3, 32'd1, 32'd1, 1'b1, 32'd3, 1'b0);
        run("R3", 4'd3, 32'd1, 32'd1, 1'b1, 32'd2, 1'b0);
        run("R3", 4'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 32'd0, 1'b1);
        run("R3", 4'd3, 32'hFFFFFFFF, 32'd0, 1'b1, 32'd0, 1'b1);
    endtask

    task automatic t_sbc();
        run("R4", 4'd1, 32'd0, 32'd1, 1'b1, 32'hFFFFFFFF, 1'b1);
        run("R4", 4'd4, 32'd10, 32'd3, 1'b1, 32'd6, 1'b0);
        run("R4", 4'd4, 32'd10, 32'd3, 1'b1, 32'd7, 1'b0);
        run("R4", 4'd1, 32'd0, 32'd1, 1'b1, 32'hFFFFFFFF, 1'b1);
        run("R4", 4'd5, 32'd5, 32'd5, 1'b1, 32'hFFFFFFFF, 1'b1);
        run("R4", 4'd5, 32'd2, 32'd9, 1'b1, 32'd6, 1'b0);
    endtask

    task automatic t_logic();
        run("R5", 4'd6, 32'hF0F0FF00, 32'h0FF0F0F0, 1'b1, 32'h00F0F000, 1'b0);
        run("R5", 4'd8, 32'hF0F0FF00, 32'h0FF0F0F0, 1'b1, 32'hFFF0FFF0, 1'b0);
        run("R5", 4'd9, 32'hF0F0FF00, 32'h0FF0F0F0, 1'b1, 32'hFF000FF0, 1'b0);
        run("R6", 4'd7, 32'hFFFF0000, 32'h0F0F0F0F, 1'b1, 32'hF0F00000, 1'b0);
        run("R6", 4'd7, 32'h12345678, 32'h00000000, 1'b1, 32'h12345678, 1'b0);
    endtask

    task automatic t_logic_keeps();
        run("R7", 4'd1, 32'd0, 32'd1, 1'b1, 32'hFFFFFFFF, 1'b1);
        run("R7", 4'd6, 32'h0, 32'h0, 1'b1, 32'h0, 1'b1);
        run("R7", 4'd9, 32'h1, 32'h1, 1'b1, 32'h0, 1'b1);
    endtask

    task automatic t_upd_off();
        run("R8", 4'd0, 32'd1, 32'd1, 1'b0, 32'd2, 1'b1);
        run("R8", 4'd1, 32'd9, 32'd2, 1'b0, 32'd7, 1'b1);
        run("R8", 4'd0, 32'd1, 32'd1, 1'b1, 32'd2, 1'b0);
        run("R8", 4'd0, 32'hFFFFFFFF, 32'd1, 1'b0, 32'd0, 1'b0);
    endtask

    task automatic t_undef();
        run("R9", 4'd12, 32'hFFFFFFFF, 32'd1, 1'b1, 32'd0, 1'b0);
        run("R9", 4'd1, 32'd0, 32'd1, 1'b1, 32'hFFFFFFFF, 1'b1);
        run("R9", 4'd15, 32'h0, 32'h0, 1'b1, 32'd0, 1'b1);
        run("R9", 4'd10, 32'h5, 32'h3, 1'b1, 32'd0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_adc();
        t_sbc();
        t_logic();
        t_logic_keeps();
        t_upd_off();
        t_undef();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule